// File: doc/BRIEF.md
# Vector Immediate Shift Engine

This block applies a shift whose count is carried in an instruction immediate to every lane of a 128-bit vector. The vector is cut into lanes of 8, 16, 32 or 64 bits, chosen by a 2-bit size code. It offers five operations: left shift, arithmetic right shift, logical right shift, and the signed and unsigned right-shift-then-add forms. The add forms sum each shifted source lane into the matching lane of a second operand. The immediate holds the count in a biased form. A left shift subtracts the lane width from the immediate. A right shift subtracts the immediate from twice the lane width.

Two modifiers narrow the result. The half-width flag processes only the lanes of the low 64 bits and clears the upper half. The scalar flag keeps only lane 0 and clears every other bit. A request is presented with `in_valid`. The result is registered on that edge and appears one cycle later with `out_valid`. In the idle cycles between requests the result register holds its value.

Top module: `vshift_imm_unit`

## Requirements
- R1: `size` selects the lane width W: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64 bits. Each lane is computed on its own, with no carry or shifted bit crossing a lane boundary.
- R2: `op` = 0 is a left shift. It fills with zeros, and the count equals `imm` minus W. This is the value of the low log2(W) bits of `imm`.
- R3: `op` = 1 is an arithmetic right shift. The count equals 2W minus `imm`, which is W minus the low log2(W) bits of `imm`, so the count lies in 1..W.
- R4: `op` = 2 is a logical right shift. It uses the same count as R3 and fills with zeros.
- R5: `op` = 3 takes the arithmetic right shift of R3 and `op` = 4 takes the logical right shift of R4. Each adds the shifted lane to the same lane of `dst`, and the sum wraps modulo 2^W.
- R6: A right-shift count equal to W, that is, low immediate bits of zero, gives a lane of copies of the sign bit for the arithmetic forms. For the logical forms it gives zero.
- R7: Bits of `imm` at and above position log2(W) have no effect on the result.
- R8: When `half` is 1, only the lanes in bits 63:0 are computed and bits 127:64 of the result are zero.
- R9: When `scalar` is 1, only lane 0 (bits W-1:0) is computed and every other result bit is zero.
- R10: On an edge where `in_valid` is 1, the result is captured and `out_valid` is 1 during the next cycle. After an edge where `in_valid` is 0, `out_valid` is 0 and `result` keeps its previous value.
- R11: While `rst_n` is low, `out_valid` and `result` are zero.
- R12: `op` codes 5, 6 and 7 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; captures the result on this edge |
| src | input | 128 | Vector to be shifted |
| dst | input | 128 | Addend vector for the accumulate operations |
| size | input | 2 | Lane width code |
| imm | input | 7 | Biased shift immediate |
| op | input | 3 | Operation select |
| half | input | 1 | 64-bit register form; clears the upper half |
| scalar | input | 1 | Operate on lane 0 only |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 128 | Registered result vector |

## Verification
The corner that is hardest to reach from the ports is a right shift by the full lane width combined with accumulation. A signed lane must collapse to all ones, and the addition that follows then wraps within the lane. Random immediates almost never hit a low field of exactly zero, so the stimulus drives immediates equal to W and to 2W-1 in every lane size. It pairs them with sources whose top lane bit is set and with addends chosen to overflow. Further passes set the high immediate bits, reserved op codes, the half and scalar modifiers and idle gaps. A behavioural model in the bench checks all of these on every clock.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
  typedef enum logic [2:0] {
    VSH_SHL  = 3'd0,
    VSH_SSHR = 3'd1,
    VSH_USHR = 3'd2,
    VSH_SACC = 3'd3,
    VSH_UACC = 3'd4
  } vsh_op_e;

  localparam int VSH_AMT_W = 7;
  localparam int VSH_NUM_SIZES = 4;
endpackage

// File: rtl/vsh_amount.sv
// Turns the biased immediate into a shift count for the selected lane width.
module vsh_amount
  import vsh_pkg::*;
#(
  parameter int IMM_W = 7
) (
  input  logic [1:0]           size,
  input  logic [IMM_W-1:0]     imm,
  input  vsh_op_e              op,
  output logic [VSH_AMT_W-1:0] amt
);
  logic [VSH_AMT_W-1:0] lane_w;
  logic [VSH_AMT_W-1:0] low_bits;

  always_comb begin
    lane_w   = VSH_AMT_W'(8) << size;
    low_bits = VSH_AMT_W'(imm) & (lane_w - VSH_AMT_W'(1));
    if (op == VSH_SHL) amt = low_bits;
    else               amt = lane_w - low_bits;
  end
endmodule

// File: rtl/vsh_lane.sv
// One lane of width LW: shift, optional accumulate.
module vsh_lane
  import vsh_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0]        a,
  input  logic [LW-1:0]        d,
  input  logic [VSH_AMT_W-1:0] amt,
  input  vsh_op_e              op,
  output logic [LW-1:0]        r
);
  logic               sgn;
  logic [LW:0]        ext;
  logic signed [LW:0] ext_sh;
  logic [LW-1:0]      shr;
  logic [LW-1:0]      shl;

  always_comb begin
    sgn    = (op == VSH_SSHR) || (op == VSH_SACC);
    ext    = {sgn & a[LW-1], a};
    ext_sh = $signed(ext) >>> amt;
    shr    = ext_sh[LW-1:0];
    shl    = (32'(amt) >= LW) ? '0 : (a << amt);
    unique case (op)
      VSH_SHL:            r = shl;
      VSH_SSHR, VSH_USHR: r = shr;
      VSH_SACC, VSH_UACC: r = d + shr;
      default:            r = '0;
    endcase
  end
endmodule

// File: rtl/vsh_size_array.sv
// All lanes of one lane width across the vector.
module vsh_size_array
  import vsh_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int LW    = 8
) (
  input  logic [VEC_W-1:0]     src,
  input  logic [VEC_W-1:0]     dst,
  input  logic [VSH_AMT_W-1:0] amt,
  input  vsh_op_e              op,
  output logic [VEC_W-1:0]     r
);
  localparam int N_LANES = VEC_W / LW;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    vsh_lane #(.LW(LW)) lane_i (
      .a   (src[i*LW +: LW]),
      .d   (dst[i*LW +: LW]),
      .amt (amt),
      .op  (op),
      .r   (r[i*LW +: LW])
    );
  end
endmodule

// File: rtl/vshift_imm_unit.sv
module vshift_imm_unit
  import vsh_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int IMM_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic [1:0]       size,
  input  logic [IMM_W-1:0] imm,
  input  logic [2:0]       op,
  input  logic             half,
  input  logic             scalar,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  localparam int HALF_W = VEC_W / 2;

  vsh_op_e                             op_e;
  logic [VSH_AMT_W-1:0]                amt;
  logic [VSH_NUM_SIZES-1:0][VEC_W-1:0] per_size;
  logic [VEC_W-1:0]                    keep_mask;
  logic [VEC_W-1:0]                    res_d;
  logic [VEC_W-1:0]                    res_nx;
  logic [VEC_W-1:0]                    res_q;
  logic                                vld_q;

  assign op_e = vsh_op_e'(op);

  vsh_amount #(.IMM_W(IMM_W)) amount_i (
    .size (size),
    .imm  (imm),
    .op   (op_e),
    .amt  (amt)
  );

  for (genvar s = 0; s < VSH_NUM_SIZES; s++) begin : g_size
    vsh_size_array #(.VEC_W(VEC_W), .LW(8 << s)) array_i (
      .src (src),
      .dst (dst),
      .amt (amt),
      .op  (op_e),
      .r   (per_size[s])
    );
  end

  always_comb begin
    keep_mask = '1;
    if (scalar) keep_mask = keep_mask & ~({VEC_W{1'b1}} << (8 << size));
    if (half)   keep_mask = keep_mask & {{(VEC_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    res_d  = per_size[size] & keep_mask;
    res_nx = in_valid ? res_d : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_nx;
      vld_q <= in_valid;
    end
  end

  assign result    = res_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/vsh_checker.sv
module vsh_checker #(
  parameter int VEC_W = 128,
  parameter int IMM_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       size,
  input logic [IMM_W-1:0] imm,
  input logic [2:0]       op,
  input logic             half,
  input logic             scalar,
  input logic             out_valid,
  input logic [VEC_W-1:0] result
);
  localparam int HALF_W = VEC_W / 2;

  logic [6:0] w_chk;
  logic       low_zero;

  always_comb begin
    w_chk    = 7'd8 << size;
    low_zero = ((7'(imm) & (w_chk - 7'd1)) == 7'd0);
  end

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_half_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && half) |=> (result[VEC_W-1:HALF_W] == '0));
  assert_scalar_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar && size == 2'd0) |=> (result[VEC_W-1:8] == '0));
  assert_full_lshr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2 && low_zero) |=> (result == '0));
  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 3'd4) |=> (result == '0));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R11: assert (!out_valid && result == '0);
    end
  end
endmodule

bind vshift_imm_unit vsh_checker #(.VEC_W(VEC_W), .IMM_W(IMM_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .size      (size),
  .imm       (imm),
  .op        (op),
  .half      (half),
  .scalar    (scalar),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/vshift_imm_unit_tb_top.sv
module vshift_imm_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 50000;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] src, dst;
  logic [1:0]   size;
  logic [6:0]   imm;
  logic [2:0]   op;
  logic         half, scalar;
  logic         out_valid;
  logic [127:0] result;

  int    total = 0;
  int    bad   = 0;
  bit    run_chk = 0;
  bit    finished = 0;
  string cur_tag = "R10";
  string exp_tag = "R10";
  logic         exp_v;
  logic [127:0] exp_r;

  vshift_imm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .dst(dst),
    .size(size), .imm(imm), .op(op), .half(half), .scalar(scalar),
    .out_valid(out_valid), .result(result)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] ref_calc(input logic [127:0] s, input logic [127:0] d,
                                            input logic [1:0] sz, input logic [6:0] im,
                                            input logic [2:0] o, input logic h, input logic sc);
    int w;
    int lanes;
    int amt;
    logic [127:0] mask, a, dv, ext, r, res;
    w     = 8 << sz;
    lanes = (h ? 64 : 128) / w;
    if (sc) lanes = 1;
    mask  = (128'd1 << w) - 128'd1;
    amt   = (o == 3'd0) ? (int'(im) % w) : (w - (int'(im) % w));
    res   = '0;
    if (o > 3'd4) return res;
    for (int i = 0; i < lanes; i++) begin
      a  = (s >> (i*w)) & mask;
      dv = (d >> (i*w)) & mask;
      if (o == 3'd0) begin
        r = (a << amt) & mask;
      end else begin
        ext = a;
        if ((o == 3'd1 || o == 3'd3) && a[w-1]) ext = a | ~mask;
        r = (ext >> amt) & mask;
        if (o >= 3'd3) r = (dv + r) & mask;
      end
      res = res | (r << (i*w));
    end
    return res;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v <= 1'b0;
      exp_r <= '0;
    end else begin
      exp_v <= in_valid;
      if (in_valid) begin
        exp_r   <= ref_calc(src, dst, size, imm, op, half, scalar);
        exp_tag <= cur_tag;
      end
    end
  end

  // compared on every falling edge
  always @(negedge clk) begin
    if (run_chk && !finished) begin
      total++;
      if (out_valid !== exp_v || result !== exp_r) begin
        bad++;
        $display("FAIL %s: got valid=%0b result=%h expected valid=%0b result=%h",
                 (exp_v ? exp_tag : "R10"), out_valid, result, exp_v, exp_r);
      end
    end
  end

  task automatic apply(input logic [127:0] s, input logic [127:0] d, input logic [1:0] sz,
                       input logic [6:0] im, input logic [2:0] o, input logic h,
                       input logic sc, input string tag);
    @(negedge clk);
    in_valid = 1'b1; src = s; dst = d; size = sz; imm = im; op = o;
    half = h; scalar = sc; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src = {4{$urandom}};
      imm = 7'($urandom);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    rst_n = 0; in_valid = 0; src = '0; dst = '0; size = '0; imm = '0;
    op = '0; half = 0; scalar = 0;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== '0) begin
      bad++;
      $display("FAIL R11: got valid=%0b result=%h expected valid=0 result=0", out_valid, result);
    end
    rst_n = 1;
    run_chk = 1;

    // R2 left shift, R1 per lane width
    for (int sz = 0; sz < 4; sz++) begin
      for (int k = 0; k < 8; k++) begin
        apply({4{32'hF0F1_8F37}}, '0, 2'(sz), 7'((8 << sz) + (k * (8 << sz)) / 8), 3'd0, 0, 0, "R2");
      end
      apply('1, '0, 2'(sz), 7'((8 << sz) * 2 - 1), 3'd0, 0, 0, "R1");
    end
    // R3 / R4 right shifts, R6 full-width count
    for (int sz = 0; sz < 4; sz++) begin
      for (int o = 1; o <= 2; o++) begin
        apply({8{16'h80F3}}, '0, 2'(sz), 7'(8 << sz), 3'(o), 0, 0, "R6");
        apply({8{16'h7E81}}, '0, 2'(sz), 7'(8 << sz), 3'(o), 0, 0, "R6");
        apply({8{16'hC001}}, '0, 2'(sz), 7'((8 << sz) * 2 - 1), 3'(o), 0, 0, (o == 1) ? "R3" : "R4");
        apply(rnd128(), '0, 2'(sz), 7'((8 << sz) + 3), 3'(o), 0, 0, (o == 1) ? "R3" : "R4");
      end
    end
    // R5 accumulate with wrap
    for (int sz = 0; sz < 4; sz++) begin
      apply({16{8'h80}}, '1, 2'(sz), 7'(8 << sz), 3'd3, 0, 0, "R5");
      apply('1, '1, 2'(sz), 7'((8 << sz) * 2 - 1), 3'd4, 0, 0, "R5");
      apply(rnd128(), rnd128(), 2'(sz), 7'((8 << sz) + 1), 3'd3, 0, 0, "R5");
      apply(rnd128(), rnd128(), 2'(sz), 7'((8 << sz) + 2), 3'd4, 0, 0, "R5");
    end
    // R7 high immediate bits ignored
    for (int sz = 0; sz < 3; sz++) begin
      for (int o = 0; o < 5; o++) begin
        apply({4{32'h9ABC_DEF1}}, {4{32'h1357_9BDF}}, 2'(sz), 7'h7F, 3'(o), 0, 0, "R7");
        apply({4{32'h9ABC_DEF1}}, {4{32'h1357_9BDF}}, 2'(sz), 7'h7F & ~7'(8 << sz), 3'(o), 0, 0, "R7");
      end
    end
    // R8 half width, R9 scalar
    for (int sz = 0; sz < 4; sz++) begin
      apply('1, '1, 2'(sz), 7'(8 << sz), 3'd1, 1, 0, "R8");
      apply(rnd128(), rnd128(), 2'(sz), 7'((8 << sz) + 1), 3'd0, 1, 0, "R8");
      apply('1, '1, 2'(sz), 7'(8 << sz), 3'd3, 0, 1, "R9");
      apply(rnd128(), rnd128(), 2'(sz), 7'((8 << sz) + 5), 3'd4, 1, 1, "R9");
    end
    // R12 reserved op codes
    for (int o = 5; o < 8; o++) apply('1, '1, 2'(o % 4), 7'd9, 3'(o), 0, 0, "R12");
    // R10 idle gaps hold the result
    apply({4{32'h1234_5678}}, '0, 2'd1, 7'd20, 3'd0, 0, 0, "R10");
    idle(4);
    apply({4{32'h8765_4321}}, '0, 2'd2, 7'd40, 3'd1, 0, 0, "R10");
    idle(1);
    // R1 random sweep
    for (int n = 0; n < 400; n++) begin
      apply(rnd128(), rnd128(), 2'($urandom), 7'($urandom), 3'($urandom % 5),
            1'($urandom % 4 == 0), 1'($urandom % 5 == 0), "R1");
      if ($urandom % 6 == 0) idle(1 + $urandom % 3);
    end
    idle(3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got no completion expected completion within %0d cycles", WDOG_CYCLES);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule